// File: doc/BRIEF.md
# Select-Steered Handshake Multiplexer and Demultiplexer

This block routes four-phase bundled-data handshakes between one shared channel and several individual channels. The direction and target of each transfer come from a select value that existing control logic already computes. Nothing in the block arbitrates. It only gates requests and acknowledges by the select, so a design that has been turned into locally timed stages can keep its original steering logic.

The demultiplexer side is pure gating. The request of the incoming channel appears only on the output channel that the select names, and that output's acknowledge is returned to the sender.

The multiplexer side forwards the request and data of the selected input to the single output. Inputs that are not selected stay stalled, with their requests pending, until the select reaches them. The acknowledge back to the selected sender comes from a state-holding element that waits for both the forwarded request and the output acknowledge to agree. It is emulated here by a register clocked by the system clock.

The select is a binary channel index. It may change only while the handshake on the side it steers is fully idle.

Top module: `hs_steer`

## Requirements
- R1: For demultiplexer output j, `dmx_out_req[j]` is high exactly when `dmx_in_req` is high and `dmx_sel` equals j, with no clock delay. It falls at once when the select moves or the input request drops.
- R2: The data of the demultiplexer output that the select names equals `dmx_in_data`. Output j occupies bits j*W to j*W+W-1 of `dmx_out_data`.
- R3: `dmx_in_ack` equals the acknowledge of the output that the select names, with no clock delay. Acknowledges on outputs that are not selected have no effect on it.
- R4: `mux_out_req` is high exactly when the input that `mux_sel` names is requesting. Requests on inputs that are not selected cause no output request and no acknowledge, and they stay pending.
- R5: While the forwarded request is high, `mux_out_data` equals the data of the selected input. Input i occupies bits i*W to i*W+W-1 of `mux_in_data`. While the forwarded request is low, `mux_out_data` is zero.
- R6: The acknowledge to the selected multiplexer input rises on the first clock edge at which the forwarded request and `mux_out_ack` are both high. It falls on the first edge at which both are low, and holds otherwise. It therefore stays high after the sender drops its request, until the output acknowledge has returned to zero. At most one input acknowledge is high at a time.
- R7: During reset, all multiplexer input acknowledges, the multiplexer output request and all demultiplexer output requests are low.
- R8: Pending multiplexer inputs are delivered whole and in the order in which the select picks them. The select changes only while the steered handshake is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the acknowledge hold state |
| rst_n | input | 1 | Active-low asynchronous reset |
| dmx_sel | input | SEL_W | Output channel index for the demultiplexer |
| dmx_in_req | input | 1 | Request of the shared incoming channel |
| dmx_in_data | input | W | Data of the shared incoming channel |
| dmx_in_ack | output | 1 | Acknowledge to the shared incoming channel |
| dmx_out_req | output | N_CH | Requests of the individual output channels |
| dmx_out_data | output | N_CH*W | Data of the individual output channels |
| dmx_out_ack | input | N_CH | Acknowledges from the individual output channels |
| mux_sel | input | SEL_W | Input channel index for the multiplexer |
| mux_in_req | input | N_CH | Requests of the individual input channels |
| mux_in_data | input | N_CH*W | Data of the individual input channels |
| mux_in_ack | output | N_CH | Acknowledges to the individual input channels |
| mux_out_req | output | 1 | Request of the shared outgoing channel |
| mux_out_data | output | W | Data of the shared outgoing channel |
| mux_out_ack | input | 1 | Acknowledge from the shared outgoing channel |

## Verification
The demultiplexer is run through a sequence of transfers to every output channel in a shuffled order. This shows whether requests and data land on the named channel and nowhere else.

A directed pattern holds the demultiplexer request high while the select moves and while a stray acknowledge is raised on an unselected output. That pattern separates true combinational gating from any latched routing.

On the multiplexer, two inputs are left requesting while a third, idle one is selected. This proves that they stall, and they are then served in an order different from their index order.

Each multiplexer transfer also samples the input acknowledge one cycle after the output acknowledge has dropped, and again one cycle later. This distinguishes the hold behaviour from plain forwarding of the output acknowledge.

// File: rtl/hs_steer_pkg.sv
package hs_steer_pkg;

    // State of the emulated state-holding agreement element.
    typedef struct packed {
        logic held;
    } agree_state_t;

    // Width of a binary channel index for a given channel count.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/hs_agree.sv
module hs_agree
    import hs_steer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    output logic y
);

    agree_state_t st_d, st_q;

    // Output follows the inputs only when they agree; otherwise it keeps its value.
    always_comb begin
        st_d = st_q;
        if (a && b) begin
            st_d.held = 1'b1;
        end else if (!a && !b) begin
            st_d.held = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y = st_q.held;

    AST_AGREE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (a != b) |=> $stable(y)); // R6

    AST_AGREE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (a && b) |=> y); // R6

    AST_AGREE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!a && !b) |=> !y); // R6

endmodule

// File: rtl/hs_demux.sv
module hs_demux
    import hs_steer_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int W    = 8,
    localparam int SEL_W = idx_width(N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic              in_req,
    input  logic [W-1:0]      in_data,
    output logic              in_ack,
    output logic [N_CH-1:0]   out_req,
    output logic [N_CH*W-1:0] out_data,
    input  logic [N_CH-1:0]   out_ack
);

    // Pure gating: no state, the request follows select and input directly.
    for (genvar j = 0; j < N_CH; j++) begin : g_out
        assign out_req[j]        = in_req && (sel == SEL_W'(j));
        assign out_data[j*W +: W] = in_data;
    end

    always_comb begin
        in_ack = 1'b0;
        for (int j = 0; j < N_CH; j++) begin
            if (sel == SEL_W'(j)) begin
                in_ack = out_ack[j];
            end
        end
    end

    AST_DMX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_req)); // R1

    AST_DMX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_req |-> (out_req == '0)); // R1

    AST_DMX_ACKSRC: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ack == '0) |-> !in_ack); // R3

endmodule

// File: rtl/hs_mux.sv
module hs_mux
    import hs_steer_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int W    = 8,
    localparam int SEL_W = idx_width(N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic [N_CH-1:0]   in_req,
    input  logic [N_CH*W-1:0] in_data,
    output logic [N_CH-1:0]   in_ack,
    output logic              out_req,
    output logic [W-1:0]      out_data,
    input  logic              out_ack
);

    logic [N_CH-1:0] req_int;
    logic            ack_held;

    // Internal request: select AND the corresponding input request.
    for (genvar i = 0; i < N_CH; i++) begin : g_in
        assign req_int[i] = in_req[i] && (sel == SEL_W'(i));
        assign in_ack[i]  = ack_held && (sel == SEL_W'(i));
    end

    assign out_req = |req_int;

    always_comb begin
        out_data = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (req_int[i]) begin
                out_data = in_data[i*W +: W];
            end
        end
    end

    hs_agree u_agree (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (out_req),
        .b     (out_ack),
        .y     (ack_held)
    );

    AST_MUX_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ack)); // R6

    AST_MUX_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_req |-> in_req[sel]); // R4

    AST_MUX_ACK_WAITS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_held) |-> $past(out_ack)); // R6

    AST_MUX_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_held) |-> !$past(out_ack)); // R6

endmodule

// File: rtl/hs_steer.sv
module hs_steer
    import hs_steer_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int W    = 8,
    localparam int SEL_W = idx_width(N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  dmx_sel,
    input  logic              dmx_in_req,
    input  logic [W-1:0]      dmx_in_data,
    output logic              dmx_in_ack,
    output logic [N_CH-1:0]   dmx_out_req,
    output logic [N_CH*W-1:0] dmx_out_data,
    input  logic [N_CH-1:0]   dmx_out_ack,
    input  logic [SEL_W-1:0]  mux_sel,
    input  logic [N_CH-1:0]   mux_in_req,
    input  logic [N_CH*W-1:0] mux_in_data,
    output logic [N_CH-1:0]   mux_in_ack,
    output logic              mux_out_req,
    output logic [W-1:0]      mux_out_data,
    input  logic              mux_out_ack
);

    hs_demux #(.N_CH(N_CH), .W(W)) u_demux (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (dmx_sel),
        .in_req   (dmx_in_req),
        .in_data  (dmx_in_data),
        .in_ack   (dmx_in_ack),
        .out_req  (dmx_out_req),
        .out_data (dmx_out_data),
        .out_ack  (dmx_out_ack)
    );

    hs_mux #(.N_CH(N_CH), .W(W)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (mux_sel),
        .in_req   (mux_in_req),
        .in_data  (mux_in_data),
        .in_ack   (mux_in_ack),
        .out_req  (mux_out_req),
        .out_data (mux_out_data),
        .out_ack  (mux_out_ack)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (mux_in_ack == '0)); // R7

endmodule

// File: tb/hs_steer_bench.sv
`timescale 1ns/1ps
module hs_steer_bench;
    localparam int N = 4;
    localparam int W = 8;
    localparam int SW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [SW-1:0]  dmx_sel = '0;
    logic           dmx_in_req = 1'b0;
    logic [W-1:0]   dmx_in_data = '0;
    logic           dmx_in_ack;
    logic [N-1:0]   dmx_out_req;
    logic [N*W-1:0] dmx_out_data;
    logic [N-1:0]   dmx_out_ack;
    logic [N-1:0]   dmx_ack_auto = '0;
    logic [N-1:0]   dmx_ack_man = '0;
    logic [SW-1:0]  mux_sel = '0;
    logic [N-1:0]   mux_in_req = '0;
    logic [N*W-1:0] mux_in_data = '0;
    logic [N-1:0]   mux_in_ack;
    logic           mux_out_req;
    logic [W-1:0]   mux_out_data;
    logic           mux_out_ack = 1'b0;
    bit             dmx_auto = 1'b1;

    assign dmx_out_ack = dmx_auto ? dmx_ack_auto : dmx_ack_man;

    hs_steer u_hs_steer (
        .clk(clk), .rst_n(rst_n),
        .dmx_sel(dmx_sel), .dmx_in_req(dmx_in_req), .dmx_in_data(dmx_in_data),
        .dmx_in_ack(dmx_in_ack), .dmx_out_req(dmx_out_req),
        .dmx_out_data(dmx_out_data), .dmx_out_ack(dmx_out_ack),
        .mux_sel(mux_sel), .mux_in_req(mux_in_req), .mux_in_data(mux_in_data),
        .mux_in_ack(mux_in_ack), .mux_out_req(mux_out_req),
        .mux_out_data(mux_out_data), .mux_out_ack(mux_out_ack)
    );

    int checks = 0;
    int errors = 0;
    int q_dmx[$];
    int q_mux[$];
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Demultiplexer receivers: pop expected {channel,data} and compare.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            for (int j = 0; j < N; j++) begin
                if (dmx_auto && dmx_out_req[j] && !dmx_ack_auto[j]) begin
                    if (q_dmx.size() == 0) begin
                        chk(1'b0, "R1 unexpected output request", j, -1);
                    end else begin
                        int e;
                        e = q_dmx.pop_front();
                        chk(e == (j * 256 + int'(dmx_out_data[j*W +: W])), "R2 routed item",
                            j * 256 + int'(dmx_out_data[j*W +: W]), e);
                    end
                    dmx_ack_auto[j] = 1'b1;
                end else if (dmx_ack_auto[j] && !dmx_out_req[j]) begin
                    dmx_ack_auto[j] = 1'b0;
                end
            end
        end
    end

    // Multiplexer receiver.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (mux_out_req && !mux_out_ack) begin
                if (q_mux.size() == 0) begin
                    chk(1'b0, "R4 unexpected output request", 1, 0);
                end else begin
                    int e;
                    e = q_mux.pop_front();
                    chk(e == int'(mux_out_data), "R5 R8 delivered data", int'(mux_out_data), e);
                end
                mux_out_ack = 1'b1;
            end else if (mux_out_ack && !mux_out_req) begin
                mux_out_ack = 1'b0;
            end
        end
    end

    // Protocol monitor: the multiplexer select must not move mid-handshake.
    initial begin
        logic [SW-1:0] prev_sel;
        bit prev_busy;
        prev_sel = '0;
        prev_busy = 1'b0;
        forever begin
            @(negedge clk);
            #3;
            if (rst_n && mux_sel != prev_sel) begin
                chk(!prev_busy, "R8 select moved during handshake", int'(mux_sel), int'(prev_sel));
            end
            prev_sel = mux_sel;
            prev_busy = mux_in_req[mux_sel] || mux_in_ack[mux_sel];
        end
    end

    task automatic dmx_send(input int ch, input int d);
        int n;
        @(negedge clk);
        dmx_sel = SW'(ch);
        dmx_in_data = W'(d);
        dmx_in_req = 1'b1;
        q_dmx.push_back(ch * 256 + d);
        n = 0;
        do begin @(negedge clk); #2; n++; end while (!dmx_in_ack && n < 50);
        chk(dmx_in_ack, "R3 acknowledge returned", int'(dmx_in_ack), 1);
        dmx_in_req = 1'b0;
        #1;
        chk(dmx_out_req == '0, "R1 request drops with input", int'(dmx_out_req), 0);
        n = 0;
        do begin @(negedge clk); #2; n++; end while (dmx_in_ack && n < 50);
    endtask

    task automatic mux_serve(input int ch, input int d);
        int n;
        @(negedge clk);
        mux_sel = SW'(ch);
        q_mux.push_back(d);
        n = 0;
        do begin @(negedge clk); #2; n++; end while (!mux_in_ack[ch] && n < 50);
        chk(mux_in_ack == N'(1 << ch), "R6 acknowledge to selected input", int'(mux_in_ack), 1 << ch);
        mux_in_req[ch] = 1'b0;
        #1;
        chk(!mux_out_req, "R4 request follows input", int'(mux_out_req), 0);
        @(negedge clk);
        #2;
        chk(mux_in_ack[ch] && !mux_out_ack, "R6 acknowledge held past output ack",
            int'({mux_in_ack[ch], mux_out_ack}), 2);
        @(negedge clk);
        #2;
        chk(mux_in_ack == '0, "R6 acknowledge released", int'(mux_in_ack), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(mux_in_ack == '0 && !mux_out_req && dmx_out_req == '0, "R7 reset state",
            int'({mux_in_ack, mux_out_req, dmx_out_req}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Demultiplexer transfers in a shuffled channel order.
        dmx_send(0, 8'h11);
        dmx_send(3, 8'hA5);
        dmx_send(1, 8'h3C);
        dmx_send(2, 8'hFF);
        dmx_send(3, 8'h00);
        chk(q_dmx.size() == 0, "R2 all demux items delivered", q_dmx.size(), 0);

        // Directed gating of the demultiplexer.
        @(negedge clk);
        dmx_auto = 1'b0;
        dmx_sel = 2'd1;
        dmx_in_data = 8'h5A;
        dmx_in_req = 1'b1;
        #1;
        chk(dmx_out_req == 4'b0010, "R1 gated to channel 1", int'(dmx_out_req), 2);
        chk(dmx_out_data[1*W +: W] == 8'h5A, "R2 data on channel 1", int'(dmx_out_data[1*W +: W]), 8'h5A);
        dmx_ack_man = 4'b0100;
        #1;
        chk(!dmx_in_ack, "R3 unselected ack ignored", int'(dmx_in_ack), 0);
        dmx_ack_man = 4'b0010;
        #1;
        chk(dmx_in_ack, "R3 selected ack forwarded", int'(dmx_in_ack), 1);
        dmx_ack_man = '0;
        dmx_sel = 2'd3;
        #1;
        chk(dmx_out_req == 4'b1000, "R1 request follows select", int'(dmx_out_req), 8);
        dmx_in_req = 1'b0;
        #1;
        chk(dmx_out_req == '0, "R1 request drops", int'(dmx_out_req), 0);
        @(negedge clk);
        dmx_auto = 1'b1;

        // Multiplexer: two inputs pending while an idle input is selected.
        @(negedge clk);
        mux_sel = 2'd0;
        mux_in_data[1*W +: W] = 8'h71;
        mux_in_data[2*W +: W] = 8'h72;
        mux_in_req = 4'b0110;
        repeat (4) @(negedge clk);
        #2;
        chk(!mux_out_req && mux_in_ack == '0, "R4 unselected inputs stall",
            int'({mux_out_req, mux_in_ack}), 0);
        chk(mux_out_data == '0, "R5 idle data zero", int'(mux_out_data), 0);
        mux_serve(2, 8'h72);
        chk(mux_in_req[1] && !mux_out_req, "R4 input 1 still pending", int'(mux_in_req), 2);
        mux_serve(1, 8'h71);

        @(negedge clk);
        mux_in_data[0*W +: W] = 8'hC0;
        mux_in_data[3*W +: W] = 8'hC3;
        mux_in_req = 4'b1001;
        mux_serve(3, 8'hC3);
        mux_serve(0, 8'hC0);
        chk(q_mux.size() == 0, "R8 all mux items delivered", q_mux.size(), 0);

        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule